// File: doc/BRIEF.md
# Opportunistic Core Frequency Boost Controller

This block chooses one shared clock ratio for all running cores of a four-core processor. The ratio is counted in 133.33 MHz bins. The controller works as a closed loop. On each evaluation strobe it looks at three inputs:

- how many cores are awake;
- whether the operating system is asking for maximum performance;
- whether temperature, power or current is over its factory limit.

From these it moves the ratio by one bin, or holds it. The ratio can rise above a programmed base only while every limit is clear. The ceiling for that rise is chosen by the number of awake cores, so fewer awake cores allow a higher ratio.

The base ratio and the per-count ceilings are inputs, driven from configuration. Sensor comparison, clock generation, voltage sequencing and the performance-state interface are outside this block. They appear only as plain input bits. The `boost_on` output tells the clock logic that the ratio is above base.

Top module: `boost_ratio_ctrl`

## Requirements
- R1: During synchronous reset (`rst_n` low at a clock edge) the ratio loads `base_ratio`, and `boost_on` is 0.
- R2: Each core has a 2-bit power-state code at bits [2k+1:2k] of `core_pstate`, encoded as 0=C0, 1=C1, 2=C3, 3=C6. Codes 0 and 1 count the core as awake; codes 2 and 3 count it as asleep.
- R3: The ceiling for k awake cores (k = 1..4) is the field `ceil_ratio[6k-1:6k-6]`. With zero awake cores the one-core field is used.
- R4: On an evaluation tick the ratio rises by exactly one bin, as long as the ratio is below the ceiling, maximum performance is requested and no limit flag is set. It never rises past the ceiling.
- R5: On a tick where any of `hot_over`, `pwr_over` or `cur_over` is set and the ratio is above base, the ratio falls by one bin. Limit flags never push the ratio below base.
- R6: Without maximum-performance request, each tick lowers a ratio above base by one bin. No rise above base happens.
- R7: The ratio changes only on the clock edge that samples `eval_tick` high, by at most one step per tick. Between ticks it holds.
- R8: If the ceiling for the current awake count is below the ratio, one tick sets the ratio equal to that ceiling, even with no limit flag set.
- R9: While zero cores are awake, ticks leave the ratio unchanged, whatever the request and limit inputs.
- R10: A ceiling field below `base_ratio` acts as `base_ratio`, so no boost is possible for that core count.
- R11: If `base_ratio` is raised above the ratio, each tick raises the ratio by one bin until it reaches base, even under limit flags.
- R12: `boost_on` is 1 exactly when the ratio is above `base_ratio`.

Rule priority on a tick, highest first: R9, R11, R6, R8, R5, R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eval_tick | input | 1 | One-cycle evaluation strobe |
| core_pstate | input | 8 | Per-core power-state codes, 2 bits per core |
| perf_max_req | input | 1 | OS requests the highest performance state |
| hot_over | input | 1 | Temperature above limit |
| pwr_over | input | 1 | Power above limit |
| cur_over | input | 1 | Current above limit |
| base_ratio | input | 6 | Base ratio in bins |
| ceil_ratio | input | 24 | Ceiling per awake-core count, 6 bits each, one-core field lowest |
| ratio | output | 6 | Current shared ratio in bins |
| boost_on | output | 1 | Ratio is above base |

## Verification
Two situations are the hardest to reach from the ports. The first is a clamp of more than one bin. The second is the ratio sitting below base. For the clamp, the stimulus first climbs to the one-core ceiling. It then wakes all four cores, whose ceiling is two bins lower, so the single-tick clamp can be told apart from a one-bin step. For the below-base case, the bench reprograms `base_ratio` upward while a limit flag is held. The ratio must then climb against the limit, one bin per tick. Zero-awake holding is checked both with and without the performance request.

// File: rtl/boost_ratio_ctrl.sv
module boost_ratio_ctrl #(
  parameter int NCORES = 4,
  parameter int RW     = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eval_tick,
  input  logic [2*NCORES-1:0]    core_pstate,
  input  logic                   perf_max_req,
  input  logic                   hot_over,
  input  logic                   pwr_over,
  input  logic                   cur_over,
  input  logic [RW-1:0]          base_ratio,
  input  logic [NCORES*RW-1:0]   ceil_ratio,
  output logic [RW-1:0]          ratio,
  output logic                   boost_on
);
  localparam int CW = $clog2(NCORES + 1);

  logic [CW-1:0] n_awake;
  logic [RW-1:0] ceil_raw, ceil_eff, ratio_nx;
  logic          limit_hit;

  always_comb begin
    n_awake = '0;
    for (int i = 0; i < NCORES; i++)
      n_awake = n_awake + CW'(!core_pstate[2*i+1]);
  end

  always_comb begin
    ceil_raw = ceil_ratio[RW-1:0];
    for (int k = 2; k <= NCORES; k++)
      if (n_awake == CW'(k)) ceil_raw = ceil_ratio[(k-1)*RW +: RW];
  end

  assign ceil_eff  = (ceil_raw < base_ratio) ? base_ratio : ceil_raw;
  assign limit_hit = hot_over | pwr_over | cur_over;

  always_comb begin
    ratio_nx = ratio;
    if (n_awake == '0)
      ratio_nx = ratio;
    else if (ratio < base_ratio)
      ratio_nx = ratio + RW'(1);
    else if (!perf_max_req) begin
      if (ratio > base_ratio) ratio_nx = ratio - RW'(1);
    end else if (ratio > ceil_eff)
      ratio_nx = ceil_eff;
    else if (limit_hit) begin
      if (ratio > base_ratio) ratio_nx = ratio - RW'(1);
    end else if (ratio < ceil_eff)
      ratio_nx = ratio + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ratio <= base_ratio;
    else if (eval_tick) ratio <= ratio_nx;
  end

  assign boost_on = ratio > base_ratio;
endmodule

// File: rtl/boost_ratio_chk.sv
module boost_ratio_chk #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eval_tick,
  input logic          perf_max_req,
  input logic          hot_over,
  input logic          pwr_over,
  input logic          cur_over,
  input logic [RW-1:0] base_ratio,
  input logic [RW-1:0] ratio
);
  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_tick |=> $stable(ratio));

  // R4
  single_bin_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio > $past(ratio)) |-> ((ratio - $past(ratio)) == RW'(1)));

  // R5
  no_rise_on_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_tick && (hot_over || pwr_over || cur_over)) |=>
      (ratio <= $past(ratio) || ratio <= $past(base_ratio)));

  // R6
  no_rise_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_tick && !perf_max_req) |=>
      (ratio <= $past(ratio) || ratio <= $past(base_ratio)));

  // R5
  base_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= base_ratio) |=> (ratio >= $past(base_ratio)));
endmodule

bind boost_ratio_ctrl boost_ratio_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick), .perf_max_req(perf_max_req),
  .hot_over(hot_over), .pwr_over(pwr_over), .cur_over(cur_over),
  .base_ratio(base_ratio), .ratio(ratio)
);

// File: tb/sim_boost_ratio_ctrl.sv
module sim_boost_ratio_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       eval_tick = 0;
  logic [7:0] core_pstate = 8'h00;
  logic       perf_max_req = 0, hot_over = 0, pwr_over = 0, cur_over = 0;
  logic [5:0] base_ratio = 6'd20;
  logic [23:0] ceil_ratio = {6'd20, 6'd21, 6'd21, 6'd22};
  logic [5:0] ratio;
  logic       boost_on;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  boost_ratio_ctrl u0 (.*);

  // fields: pstate[20:13] req[12] hot,pwr,cur[11:9] ticks[8:6] expected[5:0]
  localparam logic [20:0] VEC [15] = '{
    {8'h00, 1'b1, 3'b000, 3'd3, 6'd20},  // R4 four awake, ceiling=base
    {8'hF4, 1'b1, 3'b000, 3'd2, 6'd21},  // R2 R4 C0+C1 awake
    {8'hEC, 1'b1, 3'b000, 3'd1, 6'd22},  // R3 one awake
    {8'hEC, 1'b1, 3'b000, 3'd2, 6'd22},  // R4 stops at ceiling
    {8'hEC, 1'b1, 3'b100, 3'd1, 6'd21},  // R5 temperature
    {8'hEC, 1'b1, 3'b011, 3'd3, 6'd20},  // R5 floor at base
    {8'hDB, 1'b1, 3'b000, 3'd2, 6'd22},  // R2 single C1 awake
    {8'h01, 1'b1, 3'b000, 3'd1, 6'd20},  // R8 two-bin clamp
    {8'hEC, 1'b1, 3'b000, 3'd2, 6'd22},
    {8'hEC, 1'b0, 3'b000, 3'd1, 6'd21},  // R6
    {8'hEC, 1'b0, 3'b000, 3'd3, 6'd20},  // R6
    {8'hAA, 1'b1, 3'b000, 3'd3, 6'd20},  // R9 zero awake
    {8'hEC, 1'b1, 3'b000, 3'd1, 6'd21},
    {8'hAA, 1'b0, 3'b000, 3'd2, 6'd21},  // R9 hold without request
    {8'hEC, 1'b1, 3'b010, 3'd1, 6'd20}   // R5 power
  };

  task automatic chk(input string rq, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", rq, got, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) eval_tick = 1;
      @(negedge clk) eval_tick = 0;
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog got=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ratio", ratio, 20);
    chk("R1 boost_on", boost_on, 0);
    rst_n = 1;
    for (int v = 0; v < 15; v++) begin
      core_pstate  = VEC[v][20:13];
      perf_max_req = VEC[v][12];
      {hot_over, pwr_over, cur_over} = VEC[v][11:9];
      pulse(int'(VEC[v][8:6]));
      chk($sformatf("R4 vec%0d ratio", v), ratio, int'(VEC[v][5:0]));
      chk($sformatf("R12 vec%0d boost_on", v), boost_on, int'(VEC[v][5:0] > 6'd20));
    end
    // R7 no change without tick
    core_pstate = 8'hEC; perf_max_req = 1; {hot_over, pwr_over, cur_over} = 3'b000;
    repeat (6) @(negedge clk);
    chk("R7 hold", ratio, 20);
    pulse(1);
    chk("R7 one step", ratio, 21);
    // R10 four-awake ceiling below base
    ceil_ratio[23:18] = 6'd18;
    core_pstate = 8'h00;
    pulse(1);
    chk("R10 clamp", ratio, 20);
    pulse(2);
    chk("R10 no boost", ratio, 20);
    chk("R10 boost_on", boost_on, 0);
    // R11 base raised above ratio while over temperature
    base_ratio = 6'd24; hot_over = 1;
    pulse(1);
    chk("R11 first", ratio, 21);
    pulse(3);
    chk("R11 reach base", ratio, 24);
    pulse(1);
    chk("R11 stay", ratio, 24);
    chk("R12 at base", boost_on, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule